// File: doc/BRIEF.md
# APM Command Port with SMI Request

This block decodes the byte written to the advanced power management command port of a power-management function. Each accepted byte is sorted into one of three classes. Two reserved codes switch the platform into or out of ACPI mode by setting or clearing the SCI enable flag, which the rest of the PM control logic consumes. Every other code is a general request to firmware. It raises a system-management interrupt request, but only if the SMI gate bit in the last of four local configuration bytes is set.

The command interface is a valid/ready stream with one byte per beat. The port never applies back-pressure: `cmd_ready` is held high, so a byte is accepted on every clock edge where `cmd_valid` is high. The configuration bytes sit at local indices 0 to 3, which correspond to function offsets 0x58 to 0x5b. A strap input tells the block whether system management mode is supported. When it is not, the gate byte comes out of reset already holding the "SMM initialised" pattern. The SMI request is a level that firmware clears with a one-cycle acknowledge.

Top module: `apm_cmd_port`

## Requirements
- R1: An accepted byte 0xF1 sets `sci_en`, visible after the accepting clock edge.
- R2: An accepted byte 0xF0 clears `sci_en`, visible after the accepting clock edge.
- R3: Accepted bytes 0xF0 and 0xF1 never assert `smi_req` and never clear a pending one.
- R4: An accepted byte other than 0xF0 or 0xF1 sets `smi_req` after the accepting edge when bit 1 of configuration byte index 3 (offset 0x5b) is 1.
- R5: An accepted byte other than 0xF0 or 0xF1 leaves `smi_req` and `sci_en` unchanged when bit 1 of configuration byte index 3 is 0, whatever the other bits hold.
- R6: A synchronous reset (`rst_n` low at a clock edge) clears `sci_en`, `smi_req` and `cmd_last`. With `smm_supported` high it also clears all four configuration bytes.
- R7: With `smm_supported` low, reset loads configuration byte index 3 with 0x02 and clears bytes 0 to 2. A general command is then gated through without any configuration write.
- R8: `cmd_last` holds the most recently accepted byte, including 0xF0 and 0xF1.
- R9: `smi_req` stays high until a cycle with `smi_ack` high and no new gated general command; it is low after that edge. A gated general command in the same cycle as `smi_ack` keeps it high. Further qualifying commands while it is pending leave it a single level.
- R10: `cmd_ready` is always 1. When `cmd_valid` is 0, `cmd_data` has no effect on any output.
- R11: A cycle with `cfg_we` high writes `cfg_wdata` into configuration byte `cfg_waddr` (index 0 to 3 maps to offsets 0x58 to 0x5b). `cfg_rdata` returns byte `cfg_raddr` combinationally. Other bytes are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smm_supported | input | 1 | Strap: 1 when system management mode is available |
| cmd_valid | input | 1 | Command byte present |
| cmd_ready | output | 1 | Always 1; the port never stalls |
| cmd_data | input | 8 | Command byte |
| cmd_last | output | 8 | Last accepted command byte |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_waddr | input | 2 | Configuration byte index for writes (0 to 3 = offsets 0x58 to 0x5b) |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_raddr | input | 2 | Configuration byte index for reads |
| cfg_rdata | output | 8 | Configuration byte read data |
| sci_en | output | 1 | ACPI mode flag (SCI enable) |
| smi_req | output | 1 | Level system-management interrupt request |
| smi_ack | input | 1 | Clears a pending SMI request |

## Verification
Every state element in this block drives a port directly. A corrupted SCI flag, command register or SMI level therefore shows up on the edge right after the command that should have set it. A wrong gate byte stays hidden until the next general command. It then shows up either as a missing or spurious `smi_req` one edge later, or at once on `cfg_rdata`. A request that fails to hold or fails to clear shows up within one cycle of the acknowledge.

// File: rtl/apm_port_pkg.sv
package apm_port_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    CLS_ACPI_ON  = 2'd0,
    CLS_ACPI_OFF = 2'd1,
    CLS_GENERAL  = 2'd2
  } cmd_class_e;

  function automatic cmd_class_e classify_cmd(
    input logic [BYTE_W-1:0] code,
    input logic [BYTE_W-1:0] on_code,
    input logic [BYTE_W-1:0] off_code
  );
    if (code == on_code)       return CLS_ACPI_ON;
    else if (code == off_code) return CLS_ACPI_OFF;
    else                       return CLS_GENERAL;
  endfunction

endpackage

// File: rtl/apm_cfg_bank.sv
module apm_cfg_bank #(
  parameter int unsigned N_BYTES  = 4,
  parameter int unsigned W        = 8,
  parameter int unsigned GATE_IDX = 3,
  parameter int unsigned GATE_BIT = 1,
  localparam int unsigned AW      = (N_BYTES > 1) ? $clog2(N_BYTES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smm_supported,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata,
  output logic          smi_gate
);

  localparam logic [W-1:0] SMM_DONE_VAL = W'(1) << GATE_BIT;

  logic [W-1:0] bytes_q [N_BYTES];

  for (genvar i = 0; i < N_BYTES; i++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        if (i == GATE_IDX && !smm_supported) bytes_q[i] <= SMM_DONE_VAL;
        else                                  bytes_q[i] <= '0;
      end else if (we && waddr == AW'(i)) begin
        bytes_q[i] <= wdata;
      end
    end
  end

  assign rdata    = bytes_q[raddr];
  assign smi_gate = bytes_q[GATE_IDX][GATE_BIT];

  // R11
  cfg_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && rst_n) |=> (bytes_q[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/apm_cmd_decode.sv
module apm_cmd_decode
  import apm_port_pkg::*;
#(
  parameter int unsigned    W        = 8,
  parameter logic [W-1:0]   ON_CODE  = 8'hF1,
  parameter logic [W-1:0]   OFF_CODE = 8'hF0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         accept,
  input  logic [W-1:0] code,
  output logic         sci_en,
  output logic [W-1:0] last_cmd,
  output logic         general_hit
);

  cmd_class_e cls;
  logic       sci_q;
  logic [W-1:0] last_q;

  assign cls = classify_cmd(code, ON_CODE, OFF_CODE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sci_q  <= 1'b0;
      last_q <= '0;
    end else if (accept) begin
      last_q <= code;
      case (cls)
        CLS_ACPI_ON:  sci_q <= 1'b1;
        CLS_ACPI_OFF: sci_q <= 1'b0;
        default:      sci_q <= sci_q;
      endcase
    end
  end

  assign sci_en      = sci_q;
  assign last_cmd    = last_q;
  assign general_hit = accept && (cls == CLS_GENERAL);

  // R1
  acpi_on_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && code == ON_CODE) |=> sci_en);

  // R2
  acpi_off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && code == OFF_CODE) |=> !sci_en);

  // R8
  last_cmd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (last_cmd == $past(code)));

endmodule

// File: rtl/apm_smi_ctrl.sv
module apm_smi_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger,
  input  logic ack,
  output logic req
);

  logic req_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       req_q <= 1'b0;
    else if (trigger) req_q <= 1'b1;
    else if (ack)     req_q <= 1'b0;
  end

  assign req = req_q;

  // R9
  smi_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> req);

  // R9
  smi_ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !trigger) |=> !req);

  // R9
  smi_trigger_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |=> req);

endmodule

// File: rtl/apm_cmd_port.sv
module apm_cmd_port
  import apm_port_pkg::*;
#(
  parameter int unsigned  CFG_BYTES = 4,
  parameter int unsigned  GATE_IDX  = 3,
  parameter int unsigned  GATE_BIT  = 1,
  parameter logic [7:0]   ON_CODE   = 8'hF1,
  parameter logic [7:0]   OFF_CODE  = 8'hF0,
  localparam int unsigned CAW       = (CFG_BYTES > 1) ? $clog2(CFG_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smm_supported,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [BYTE_W-1:0] cmd_data,
  output logic [BYTE_W-1:0] cmd_last,
  input  logic              cfg_we,
  input  logic [CAW-1:0]    cfg_waddr,
  input  logic [BYTE_W-1:0] cfg_wdata,
  input  logic [CAW-1:0]    cfg_raddr,
  output logic [BYTE_W-1:0] cfg_rdata,
  output logic              sci_en,
  output logic              smi_req,
  input  logic              smi_ack
);

  logic accept;
  logic general_hit;
  logic smi_gate;

  assign cmd_ready = 1'b1;
  assign accept    = cmd_valid && cmd_ready;

  apm_cfg_bank #(
    .N_BYTES (CFG_BYTES),
    .W       (BYTE_W),
    .GATE_IDX(GATE_IDX),
    .GATE_BIT(GATE_BIT)
  ) u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .smm_supported(smm_supported),
    .we           (cfg_we),
    .waddr        (cfg_waddr),
    .wdata        (cfg_wdata),
    .raddr        (cfg_raddr),
    .rdata        (cfg_rdata),
    .smi_gate     (smi_gate)
  );

  apm_cmd_decode #(
    .W       (BYTE_W),
    .ON_CODE (ON_CODE),
    .OFF_CODE(OFF_CODE)
  ) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .code       (cmd_data),
    .sci_en     (sci_en),
    .last_cmd   (cmd_last),
    .general_hit(general_hit)
  );

  apm_smi_ctrl u_smi (
    .clk    (clk),
    .rst_n  (rst_n),
    .trigger(general_hit && smi_gate),
    .ack    (smi_ack),
    .req    (smi_req)
  );

  // R3
  reserved_no_smi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_data == ON_CODE || cmd_data == OFF_CODE) && !smi_req)
      |=> !smi_req);

  // R4
  gated_cmd_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_data != ON_CODE && cmd_data != OFF_CODE && smi_gate)
      |=> smi_req);

  // R5
  ungated_cmd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !smi_gate && !smi_req && !smi_ack) |=> !smi_req);

  // R10
  idle_keeps_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(cmd_last));

endmodule

// File: tb/tb_apm_cmd_port.sv
module tb_apm_cmd_port;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smm_supported = 1'b1;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [7:0] cmd_data = 8'h00;
  logic [7:0] cmd_last;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_waddr = 2'd0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [1:0] cfg_raddr = 2'd0;
  logic [7:0] cfg_rdata;
  logic       sci_en;
  logic       smi_req;
  logic       smi_ack = 1'b0;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  apm_cmd_port dut (
    .clk(clk), .rst_n(rst_n), .smm_supported(smm_supported),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .cmd_last(cmd_last), .cfg_we(cfg_we), .cfg_waddr(cfg_waddr),
    .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .sci_en(sci_en), .smi_req(smi_req), .smi_ack(smi_ack)
  );

  // {gate byte, command, expected sci_en, expected smi_req}
  localparam logic [17:0] VEC [11] = '{
    {8'h02, 8'hF1, 1'b1, 1'b0},
    {8'h02, 8'h55, 1'b1, 1'b1},
    {8'h00, 8'h55, 1'b1, 1'b0},
    {8'h00, 8'hF0, 1'b0, 1'b0},
    {8'h02, 8'hF0, 1'b0, 1'b0},
    {8'hFD, 8'h12, 1'b0, 1'b0},
    {8'h02, 8'h00, 1'b0, 1'b1},
    {8'h02, 8'hFF, 1'b0, 1'b1},
    {8'h02, 8'hF2, 1'b0, 1'b1},
    {8'h00, 8'hF1, 1'b1, 1'b0},
    {8'h02, 8'hEF, 1'b1, 1'b1}
  };

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst_n = 1'b0;
    smm_supported = strap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send_cmd(input logic [7:0] b);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = b;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_waddr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic read_cfg(input logic [1:0] a, output logic [7:0] d);
    cfg_raddr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic pulse_ack();
    @(negedge clk);
    smi_ack = 1'b1;
    @(negedge clk);
    smi_ack = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] rd;

    // R6: reset state with SMM supported
    do_reset(1'b1);
    @(negedge clk);
    check("R6", "sci_en", {7'd0, sci_en}, 8'h00);
    check("R6", "smi_req", {7'd0, smi_req}, 8'h00);
    check("R6", "cmd_last", cmd_last, 8'h00);
    for (int a = 0; a < 4; a++) begin
      read_cfg(a[1:0], rd);
      check("R6", "cfg byte", rd, 8'h00);
    end
    check("R10", "cmd_ready", {7'd0, cmd_ready}, 8'h01);

    // R1 R2 R3 R4 R5 R8: vector walk
    for (int i = 0; i < 11; i++) begin
      cfg_write(2'd3, VEC[i][17:10]);
      send_cmd(VEC[i][9:2]);
      check("R1 R2 R5", "sci_en", {7'd0, sci_en}, {7'd0, VEC[i][1]});
      check("R3 R4 R5", "smi_req", {7'd0, smi_req}, {7'd0, VEC[i][0]});
      check("R8", "cmd_last", cmd_last, VEC[i][9:2]);
      if (VEC[i][0]) begin
        pulse_ack();
        check("R9", "smi_req after ack", {7'd0, smi_req}, 8'h00);
      end
    end

    // R9: hold, repeat while pending, single ack clears
    cfg_write(2'd3, 8'h02);
    send_cmd(8'h21);
    repeat (5) @(negedge clk);
    check("R9", "smi_req held", {7'd0, smi_req}, 8'h01);
    send_cmd(8'h22);
    check("R9", "smi_req second cmd", {7'd0, smi_req}, 8'h01);
    pulse_ack();
    repeat (3) @(negedge clk);
    check("R9", "smi_req single level", {7'd0, smi_req}, 8'h00);

    // R9: command and ack in the same cycle keep the request
    send_cmd(8'h30);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_data = 8'h31; smi_ack = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; smi_ack = 1'b0;
    check("R9", "smi_req cmd+ack", {7'd0, smi_req}, 8'h01);

    // R3: reserved codes leave a pending request alone
    send_cmd(8'hF1);
    check("R3", "smi_req kept by F1", {7'd0, smi_req}, 8'h01);
    check("R1", "sci_en", {7'd0, sci_en}, 8'h01);
    pulse_ack();

    // R10: data without valid has no effect
    @(negedge clk);
    cmd_data = 8'h77;
    repeat (3) @(negedge clk);
    check("R10", "cmd_last idle", cmd_last, 8'hF1);
    check("R10", "smi_req idle", {7'd0, smi_req}, 8'h00);
    check("R10", "sci_en idle", {7'd0, sci_en}, 8'h01);

    // R11: byte writes land in their own slot
    cfg_write(2'd0, 8'hA5);
    cfg_write(2'd1, 8'h5A);
    cfg_write(2'd2, 8'h3C);
    read_cfg(2'd0, rd); check("R11", "cfg 0x58", rd, 8'hA5);
    read_cfg(2'd1, rd); check("R11", "cfg 0x59", rd, 8'h5A);
    read_cfg(2'd2, rd); check("R11", "cfg 0x5a", rd, 8'h3C);
    read_cfg(2'd3, rd); check("R11", "cfg 0x5b untouched", rd, 8'h02);

    // R6: reset clears ACPI mode and bytes again
    do_reset(1'b1);
    @(negedge clk);
    check("R6", "sci_en after reset", {7'd0, sci_en}, 8'h00);
    read_cfg(2'd0, rd); check("R6", "cfg 0x58 after reset", rd, 8'h00);

    // R7: no SMM support forces the gate byte
    do_reset(1'b0);
    @(negedge clk);
    read_cfg(2'd3, rd); check("R7", "cfg 0x5b", rd, 8'h02);
    read_cfg(2'd1, rd); check("R7", "cfg 0x59", rd, 8'h00);
    send_cmd(8'h33);
    check("R7", "smi_req gated by strap", {7'd0, smi_req}, 8'h01);

    finish_run();
  end

endmodule